// File: doc/BRIEF.md
# Pulsed Interrupt Aggregator with End-of-Interrupt Re-arm

This block gathers a parameterised set of hardware interrupt sources into one interrupt line that is driven as a single-cycle pulse. Each source holds a pending bit and a mask-enable bit. A hardware event sets the pending bit. Software can set or clear pending bits and enable bits through a small register write port. Every write address is write-ones-only: a 1 acts on the matching source and a 0 leaves it alone. A combinational read port returns the raw pending bits, the enable bits or the masked pending bits.

After it sends a pulse, the block stops firing until it is re-armed. A re-arm comes from the end-of-interrupt input or from any write to one of the four interrupt registers. Once re-armed, the block sends a fresh pulse if any enabled source is still pending. Software therefore acknowledges each pulse and cannot miss a source that stays active. The sequencing is a three-state machine:

- State ARMED: waiting for pending work.
- State FIRE: the pulse cycle.
- State HOLD: fired and waiting for a re-arm.

Its transitions are:

- DETECT (ARMED to FIRE) when any enabled source is pending.
- RETIRE (FIRE to HOLD) when there is no re-arm in the pulse cycle.
- QUICK_REARM (FIRE to ARMED) when a re-arm arrives in the pulse cycle.
- REARM (HOLD to ARMED) on end-of-interrupt or a register write.

Top module: `irq_pulse_agg`

## Requirements
- R1: After reset, all pending and enable bits are 0, the machine is ARMED and `irq_pulse` is low.
- R2: A high `hw_evt[i]` sampled at a clock edge sets pending bit i at that edge. The bit reads back as 1 from address 0 or 1 on the following cycle. Other bits are unchanged.
- R3: A write to address 0 sets every pending bit whose data bit is 1. A write to address 1 clears every pending bit whose data bit is 1. Bits written as 0 are unchanged.
- R4: A write to address 2 sets every enable bit whose data bit is 1. A write to address 3 clears every enable bit whose data bit is 1. Bits written as 0 are unchanged. Addresses 2 and 3 both read the enable bits.
- R5: Address 4 reads the bitwise AND of the pending bits and the enable bits. Any other unused read address returns 0.
- R6: When the machine is ARMED and some enabled source is pending at a clock edge, `irq_pulse` is high for exactly one cycle after that edge. For a stimulus driven before edge k, the pulse is therefore seen after edge k+1.
- R7: After a pulse, no further pulse occurs until a re-arm (end-of-interrupt or register write), even if enabled sources are pending or new events arrive.
- R8: A one-cycle `eoi` re-arms the machine. A new pulse follows if an enabled source is still pending, and none follows if nothing enabled is pending.
- R9: A write to addresses 0 to 3 re-arms the machine. A write to any other address changes no bit and does not re-arm.
- R10: If a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R11: A pending source whose enable bit is 0 never causes a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | NSRC | Per-source hardware event, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 pend set, 1 pend clear, 2 enable set, 3 enable clear) |
| wr_data | input | NSRC | Write data, one bit per source |
| rd_addr | input | 3 | Read address (0/1 pending, 2/3 enable, 4 masked) |
| rd_data | output | NSRC | Combinational read data |
| eoi | input | 1 | End-of-interrupt, requests a re-check |
| irq_pulse | output | 1 | Single-cycle aggregated interrupt pulse |

## Verification
Pending bits are raised by hardware while their enables are off, which separates the raw view from the masked view and shows that disabled sources stay silent. Pulses are triggered four ways: by an enable-set write, by a software pending-set write, by end-of-interrupt with work left, and by end-of-interrupt with no work left. Together these tell a correct re-check apart from a pulse that always or never fires. A hold window with sources still pending, and a write to an unused address, separate real re-arm sources from spurious ones. A same-cycle hardware set and software clear on one bit checks which side wins.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PEND_SET = 3'd0,
        A_PEND_CLR = 3'd1,
        A_EN_SET   = 3'd2,
        A_EN_CLR   = 3'd3,
        A_MASKED   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HOLD  = 2'd2
    } arm_state_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   hw_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NSRC-1:0]   rd_data,
    output logic [NSRC-1:0]   pend_q,
    output logic [NSRC-1:0]   en_q,
    output logic              reg_wr
);
    logic [NSRC-1:0] pset, pclr, eset, eclr, masked;

    always_comb begin
        pset = '0;
        pclr = '0;
        eset = '0;
        eclr = '0;
        if (wr_en) begin
            unique case (wr_addr)
                A_PEND_SET: pset = wr_data;
                A_PEND_CLR: pclr = wr_data;
                A_EN_SET:   eset = wr_data;
                A_EN_CLR:   eclr = wr_data;
                default:    ;
            endcase
        end
    end

    assign reg_wr = wr_en && (wr_addr <= A_EN_CLR);
    assign masked = pend_q & en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else begin
                // hardware event dominates a same-cycle software clear
                pend_q[i] <= hw_evt[i] | pset[i] | (pend_q[i] & ~pclr[i]);
                en_q[i]   <= eset[i] | (en_q[i] & ~eclr[i]);
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_PEND_SET, A_PEND_CLR: rd_data = pend_q;
            A_EN_SET, A_EN_CLR:     rd_data = en_q;
            A_MASKED:               rd_data = masked;
            default:                rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_arm_fsm.sv
module irq_arm_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic rearm,
    output logic irq_pulse
);
    arm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (pending) state_d = ST_FIRE;                   // DETECT
            ST_FIRE:  state_d = rearm ? ST_ARMED : ST_HOLD;             // QUICK_REARM / RETIRE
            ST_HOLD:  if (rearm) state_d = ST_ARMED;                    // REARM
            default:  state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq_pulse = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/irq_pulse_agg.sv
module irq_pulse_agg
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   hw_evt,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic [2:0]        rd_addr,
    output logic [NSRC-1:0]   rd_data,
    input  logic              eoi,
    output logic              irq_pulse
);
    logic [NSRC-1:0] pend_q, en_q;
    logic            reg_wr, rearm, pending;

    irq_src_regs #(.NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_evt  (hw_evt),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .reg_wr  (reg_wr)
    );

    assign pending = |(pend_q & en_q);
    assign rearm   = eoi | reg_wr;

    irq_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .rearm     (rearm),
        .irq_pulse (irq_pulse)
    );
endmodule

// File: rtl/irq_pulse_agg_chk.sv
module irq_pulse_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] hw_evt,
    input logic            wr_en,
    input logic [2:0]      wr_addr,
    input logic [NSRC-1:0] wr_data,
    input logic            rearm,
    input logic [NSRC-1:0] pend_q,
    input logic [NSRC-1:0] en_q,
    input logic            irq_pulse
);
    logic held;

    always_ff @(posedge clk) begin
        if (!rst_n)                  held <= 1'b0;
        else if (irq_pulse && !rearm) held <= 1'b1;
        else if (rearm)              held <= 1'b0;
    end

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !irq_pulse);

    a_r11_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(|(pend_q & en_q)));

    a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((pend_q & $past(hw_evt)) == $past(hw_evt)));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PEND_CLR) |=> ((pend_q & $past(wr_data) & ~$past(hw_evt)) == '0));

    a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_SET) |=> ((en_q & $past(wr_data)) == $past(wr_data)));
endmodule

bind irq_pulse_agg irq_pulse_agg_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_evt    (hw_evt),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rearm     (rearm),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .irq_pulse (irq_pulse)
);

// File: tb/irq_pulse_agg_bench.sv
module irq_pulse_agg_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hw_evt = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         eoi = 1'b0;
    logic         irq_pulse;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    int pulses = 0;
    int expq[$];
    bit done = 1'b0;

    irq_pulse_agg #(.NSRC(N)) u_irq_pulse_agg (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .eoi(eoi), .irq_pulse(irq_pulse)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every observed pulse must match the next expected cycle
    always @(negedge clk) begin
        if (rst_n && irq_pulse && !done) begin
            pulses++;
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R7/R11 unexpected pulse: actual cycle %0d, expected none", cyc);
            end else begin
                int e;
                e = expq.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R6 pulse timing: actual cycle %0d, expected %0d", cyc, e);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h, expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    // driver: one write cycle; pushes the expected pulse cycle when one is due
    task automatic wr(input logic [2:0] a, input logic [N-1:0] d, input bit exp_pulse);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (exp_pulse) expq.push_back(cyc + 2);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic evt(input logic [N-1:0] d);
        @(negedge clk);
        hw_evt = d;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic pulse_eoi(input bit exp_pulse);
        @(negedge clk);
        eoi = 1'b1;
        if (exp_pulse) expq.push_back(cyc + 2);
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int p0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(3'd0, 8'h00, "R1 pending after reset");
        rd(3'd2, 8'h00, "R1 enable after reset");
        check("R1 no pulse after reset", {7'd0, irq_pulse}, 8'h00);

        // R2 hardware sets; R11 disabled sources stay silent
        evt(8'h05);
        rd(3'd1, 8'h05, "R2 raw pending after events");
        rd(3'd4, 8'h00, "R5 masked with no enables");
        idle(3);

        // R4 enable set and R6 pulse timing
        wr(3'd2, 8'h01, 1'b1);
        rd(3'd3, 8'h01, "R4 enable after set");
        idle(4);

        // R7 no new pulse while held, even with fresh events
        p0 = pulses;
        evt(8'h01);
        idle(5);
        check("R7 held, no pulse", 8'(pulses - p0), 8'h00);

        // R8 eoi with pending work
        pulse_eoi(1'b1);
        idle(3);

        // R3 clear one pending bit (rearms, nothing enabled pending)
        wr(3'd1, 8'h01, 1'b0);
        rd(3'd0, 8'h04, "R3 pending after clear");

        // R3 software set, then R6 via enable
        wr(3'd0, 8'h02, 1'b0);
        rd(3'd0, 8'h06, "R3 pending after software set");
        wr(3'd2, 8'h02, 1'b1);
        rd(3'd4, 8'h02, "R5 masked pending");
        idle(4);

        // R8 eoi with nothing pending
        wr(3'd1, 8'h02, 1'b0);
        p0 = pulses;
        pulse_eoi(1'b0);
        idle(4);
        check("R8 eoi without pending", 8'(pulses - p0), 8'h00);

        // R9 write to unused address neither changes bits nor rearms
        wr(3'd0, 8'h01, 1'b1);
        idle(4);
        p0 = pulses;
        wr(3'd5, 8'hFF, 1'b0);
        idle(4);
        check("R9 unused address no rearm", 8'(pulses - p0), 8'h00);
        rd(3'd0, 8'h05, "R9 pending untouched");
        rd(3'd2, 8'h03, "R9 enable untouched");
        rd(3'd6, 8'h00, "R5 unused read address");
        wr(3'd3, 8'h01, 1'b0);
        rd(3'd2, 8'h02, "R4 enable after clear");
        idle(3);

        // R10 hardware set wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h05; hw_evt = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; hw_evt = '0;
        rd(3'd0, 8'h01, "R10 hardware beats clear");
        idle(3);

        // R6 pulse from enabling all, then R2 new events while held
        wr(3'd2, 8'hFF, 1'b1);
        idle(3);
        evt(8'hA0);
        rd(3'd0, 8'hA1, "R2 pending after second event pattern");
        pulse_eoi(1'b1);
        idle(5);

        tests++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R6 missing pulses: actual %0d left, expected 0", expq.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule